// File: doc/BRIEF.md
# Two-Bank Steerable Interrupt Controller

This block gathers forty level-sensitive interrupt lines into two banks: a wide bank of thirty-two sources (0 to 31) and a narrow bank of eight (32 to 39). Each bank has an enable mask and a class-select register. The class-select register sends each source either to the normal request line (`irq`) or to the fast request line (`fiq`). The pending state is not latched. It is a registered copy of the line levels, so a source drops out by itself when its line goes low.

Software reaches the block through a synchronous register port that uses byte offsets. Reads of the two filtered pending views already apply the mask and the class. A control register sets an idle mask, which lets masked sources still wake a halted core through `wake`. There are forty priority slots, each holding a valid flag and a source number. A resolver walks these slots and reports the most urgent active source of each class in one highest-priority word.

Top module: `intc_banked`

## Requirements
- R1: The pending state is a copy of `src` taken on every clock. The raw pending registers (0x10 for sources 0–31, 0xAC for 32–39) return it unfiltered. It cannot be cleared by software.
- R2: Offsets 0x00 and 0x9C return pending AND enabled AND NOT class-select. Offsets 0x0C and 0xA8 return pending AND enabled AND class-select.
- R3: `fiq` is 1 when any pending, enabled source has class-select 1. `irq` is 1 when any pending, enabled source has class-select 0. Both are registered and change on the clock edge that captures a source level change or a register write.
- R4: The mask registers (0x04 and 0xA0) and the class-select registers (0x08 and 0xA4) are read/write.
- R5: At control offset 0x14, a write with bit 0 = 1 clears the idle mask and a write with bit 0 = 0 sets it to all ones. A read returns 1 when the idle mask is clear and 0 otherwise.
- R6: `wake` is 1, one edge after the inputs, when `halted` is 1 and pending AND (enabled OR idle mask) is nonzero. Otherwise it is 0.
- R7: Priority slot n sits at 0x1C+4n for n < 32 and at 0xB0+4(n−32) for n ≥ 32. It keeps write bits 31 and 5:0, and all other bits read as 0.
- R8: Offset 0x18 returns the highest-priority word. Bit 31 marks a valid normal-class source, whose number is in bits 21:16. Bit 15 marks a valid fast-class source, whose number is in bits 5:0. With nothing found the word is 0x003F003F. A slot counts only if its bit 31 is set and its number is below 40, and the lowest-numbered qualifying slot wins.
- R9: In the narrow-bank registers only bits 7:0 exist. Bits 31:8 read as 0.
- R10: Reads from unmapped or misaligned offsets return 0. Writes there, or to pending registers, change nothing.
- R11: After reset the mask, class-select, pending, idle mask and priority slots are zero, and `irq`, `fiq`, `wake` and `rdata` are 0.
- R12: `rdata` is loaded on the clock edge at which `rd_en` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src | input | 40 | Interrupt source levels |
| halted | input | 1 | Core is halted |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Normal-class request |
| fiq | output | 1 | Fast-class request |
| wake | output | 1 | Wake request for a halted core |

## Verification
On every cycle the assertions check four things: the pending state tracks the line levels one edge late, the two request outputs agree with the stored pending, mask and class state, a wake never appears unless the core was halted, and any valid field in the highest-priority word is backed by an asserted request line. Only the bench's scenarios can show the register map itself. That covers the filtered read views, the priority slot storage and bit trimming, the ordering among priority slots, the idle-mask control, and the lack of effect of writes to pending or unmapped offsets.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_IPEND_LO = 'h00;
  localparam int OFF_MASK_LO  = 'h04;
  localparam int OFF_CLS_LO   = 'h08;
  localparam int OFF_FPEND_LO = 'h0C;
  localparam int OFF_RAW_LO   = 'h10;
  localparam int OFF_CTL      = 'h14;
  localparam int OFF_HP       = 'h18;
  localparam int OFF_PRIO_LO  = 'h1C;
  localparam int OFF_IPEND_HI = 'h9C;
  localparam int OFF_MASK_HI  = 'hA0;
  localparam int OFF_CLS_HI   = 'hA4;
  localparam int OFF_FPEND_HI = 'hA8;
  localparam int OFF_RAW_HI   = 'hAC;
  localparam int OFF_PRIO_HI  = 'hB0;
  localparam int LO_W         = 32;
  localparam int IDW          = 6;
  localparam int DW           = 32;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         mask_we,
  input  logic         cls_we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] pend_d,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] cls_d,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] cls_q
);
  always_comb begin
    pend_d = src;
    mask_d = mask_q;
    cls_d  = cls_q;
    if (mask_we) mask_d = wval;
    if (cls_we)  cls_d  = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      cls_q  <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      cls_q  <= cls_d;
    end
  end
endmodule

// File: rtl/intc_prio_file.sv
module intc_prio_file #(
  parameter int N   = 40,
  parameter int IDW = 6,
  localparam int XW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [XW-1:0]       widx,
  input  logic                wvld,
  input  logic [IDW-1:0]      wid,
  output logic [N-1:0]        vld_q,
  output logic [N-1:0][IDW-1:0] id_q
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic           en;
    logic           vld_d;
    logic [IDW-1:0] id_d;
    assign en = we && (widx == XW'(g));
    always_comb begin
      vld_d = vld_q[g];
      id_d  = id_q[g];
      if (en) begin
        vld_d = wvld;
        id_d  = wid;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        id_q[g]  <= '0;
      end else begin
        vld_q[g] <= vld_d;
        id_q[g]  <= id_d;
      end
    end
  end
endmodule

// File: rtl/intc_hp_resolve.sv
module intc_hp_resolve #(
  parameter int N   = 40,
  parameter int IDW = 6
) (
  input  logic [N-1:0]          act,
  input  logic [N-1:0]          cls,
  input  logic [N-1:0]          vld,
  input  logic [N-1:0][IDW-1:0] id,
  output logic [31:0]           hp
);
  localparam int EXT = 2 ** IDW;
  logic [EXT-1:0] act_x;
  logic [EXT-1:0] cls_x;

  always_comb begin
    act_x = '0;
    cls_x = '0;
    act_x[N-1:0] = act;
    cls_x[N-1:0] = cls;
  end

  // Walk from the last slot to the first so the lowest slot wins.
  always_comb begin
    hp = 32'h003F_003F;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && (int'(id[i]) < N)) begin
        if (act_x[id[i]] && cls_x[id[i]]) begin
          hp[15:0] = 16'h8000 | 16'(id[i]);
        end
        if (act_x[id[i]] && !cls_x[id[i]]) begin
          hp[31:16] = 16'h8000 | 16'(id[i]);
        end
      end
    end
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               halted,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq,
  output logic               fiq,
  output logic               wake
);
  import intc_pkg::*;
  localparam int HI_W = NUM_SRC - LO_W;
  localparam int XW   = $clog2(NUM_SRC);

  function automatic logic [ADDR_W-1:0] prio_off(input int i);
    if (i < LO_W) return ADDR_W'(OFF_PRIO_LO + 4 * i);
    return ADDR_W'(OFF_PRIO_HI + 4 * (i - LO_W));
  endfunction

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // write decode
  logic we_mask_lo, we_cls_lo, we_mask_hi, we_cls_hi, we_ctl;
  assign we_mask_lo = wr_en && (addr == ADDR_W'(OFF_MASK_LO));
  assign we_cls_lo  = wr_en && (addr == ADDR_W'(OFF_CLS_LO));
  assign we_mask_hi = wr_en && (addr == ADDR_W'(OFF_MASK_HI));
  assign we_cls_hi  = wr_en && (addr == ADDR_W'(OFF_CLS_HI));
  assign we_ctl     = wr_en && (addr == ADDR_W'(OFF_CTL));

  logic          pr_hit;
  logic [XW-1:0] pr_idx;
  always_comb begin
    pr_hit = 1'b0;
    pr_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr == prio_off(i)) begin
        pr_hit = 1'b1;
        pr_idx = XW'(i);
      end
    end
  end

  // banks
  logic [LO_W-1:0] pend_lo_d, mask_lo_d, cls_lo_d, pend_lo_q, mask_lo_q, cls_lo_q;
  logic [HI_W-1:0] pend_hi_d, mask_hi_d, cls_hi_d, pend_hi_q, mask_hi_q, cls_hi_q;

  intc_bank #(.W(LO_W)) u_lo (
    .clk(clk), .rst_n(rst_i_n), .src(src[LO_W-1:0]),
    .mask_we(we_mask_lo), .cls_we(we_cls_lo), .wval(wdata[LO_W-1:0]),
    .pend_d(pend_lo_d), .mask_d(mask_lo_d), .cls_d(cls_lo_d),
    .pend_q(pend_lo_q), .mask_q(mask_lo_q), .cls_q(cls_lo_q)
  );

  intc_bank #(.W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_i_n), .src(src[NUM_SRC-1:LO_W]),
    .mask_we(we_mask_hi), .cls_we(we_cls_hi), .wval(wdata[HI_W-1:0]),
    .pend_d(pend_hi_d), .mask_d(mask_hi_d), .cls_d(cls_hi_d),
    .pend_q(pend_hi_q), .mask_q(mask_hi_q), .cls_q(cls_hi_q)
  );

  // priority slots
  logic [NUM_SRC-1:0]          pr_vld;
  logic [NUM_SRC-1:0][IDW-1:0] pr_id;
  intc_prio_file #(.N(NUM_SRC), .IDW(IDW)) u_prio (
    .clk(clk), .rst_n(rst_i_n), .we(wr_en && pr_hit), .widx(pr_idx),
    .wvld(wdata[31]), .wid(wdata[IDW-1:0]), .vld_q(pr_vld), .id_q(pr_id)
  );

  // combined state views
  logic [NUM_SRC-1:0] pend_all, mask_all, cls_all;
  assign pend_all = {pend_hi_q, pend_lo_q};
  assign mask_all = {mask_hi_q, mask_lo_q};
  assign cls_all  = {cls_hi_q, cls_lo_q};

  logic [31:0] hp_word;
  intc_hp_resolve #(.N(NUM_SRC), .IDW(IDW)) u_hp (
    .act(pend_all & mask_all), .cls(cls_all), .vld(pr_vld), .id(pr_id), .hp(hp_word)
  );

  // idle mask (1 = all ones)
  logic idle_d, idle_q;
  always_comb begin
    idle_d = idle_q;
    if (we_ctl) idle_d = ~wdata[0];
  end

  // request outputs, next state
  logic irq_d, fiq_d, wake_d;
  logic [NUM_SRC-1:0] act_d, wk_d;
  always_comb begin
    act_d  = {pend_hi_d, pend_lo_d} & {mask_hi_d, mask_lo_d};
    wk_d   = {pend_hi_d, pend_lo_d} & ({mask_hi_d, mask_lo_d} | {NUM_SRC{idle_d}});
    irq_d  = |(act_d & ~{cls_hi_d, cls_lo_d});
    fiq_d  = |(act_d & {cls_hi_d, cls_lo_d});
    wake_d = halted && (|wk_d);
  end

  // read mux
  logic [31:0] rd_d;
  always_comb begin
    rd_d = 32'h0;
    unique case (addr)
      ADDR_W'(OFF_IPEND_LO): rd_d = DW'(pend_lo_q & mask_lo_q & ~cls_lo_q);
      ADDR_W'(OFF_FPEND_LO): rd_d = DW'(pend_lo_q & mask_lo_q & cls_lo_q);
      ADDR_W'(OFF_MASK_LO):  rd_d = DW'(mask_lo_q);
      ADDR_W'(OFF_CLS_LO):   rd_d = DW'(cls_lo_q);
      ADDR_W'(OFF_RAW_LO):   rd_d = DW'(pend_lo_q);
      ADDR_W'(OFF_IPEND_HI): rd_d = DW'(pend_hi_q & mask_hi_q & ~cls_hi_q);
      ADDR_W'(OFF_FPEND_HI): rd_d = DW'(pend_hi_q & mask_hi_q & cls_hi_q);
      ADDR_W'(OFF_MASK_HI):  rd_d = DW'(mask_hi_q);
      ADDR_W'(OFF_CLS_HI):   rd_d = DW'(cls_hi_q);
      ADDR_W'(OFF_RAW_HI):   rd_d = DW'(pend_hi_q);
      ADDR_W'(OFF_CTL):      rd_d = {31'h0, ~idle_q};
      ADDR_W'(OFF_HP):       rd_d = hp_word;
      default: begin
        if (pr_hit) rd_d = {pr_vld[pr_idx], 25'h0, pr_id[pr_idx]};
      end
    endcase
  end

  logic [31:0] rdata_d;
  assign rdata_d = rd_en ? rd_d : rdata;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      idle_q <= 1'b0;
      irq    <= 1'b0;
      fiq    <= 1'b0;
      wake   <= 1'b0;
      rdata  <= 32'h0;
    end else begin
      idle_q <= idle_d;
      irq    <= irq_d;
      fiq    <= fiq_d;
      wake   <= wake_d;
      rdata  <= rdata_d;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[30:LO_W-2], wdata[30:6]};
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
  parameter int NUM_SRC = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src,
  input logic               halted,
  input logic               irq,
  input logic               fiq,
  input logic               wake,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] cls,
  input logic [31:0]        hp
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> pend == $past(src));

  p_irq_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend & mask & ~cls));

  p_fiq_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == |(pend & mask & cls));

  p_wake_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wake) |-> $past(halted));

  p_hp_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hp[31] |-> irq);

  p_hp_fiq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hp[15] |-> fiq);
endmodule

bind intc_banked intc_banked_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .src(src), .halted(halted),
  .irq(irq), .fiq(fiq), .wake(wake),
  .pend(pend_all), .mask(mask_all), .cls(cls_all), .hp(hp_word)
);

// File: tb/sim_intc_banked.sv
`timescale 1ns/1ps
module sim_intc_banked;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] src;
  logic        halted, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, fiq, wake;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  intc_banked u0 (.clk(clk), .rst_n(rst_n), .src(src), .halted(halted),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .fiq(fiq), .wake(wake));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_src(input logic [39:0] v);
    src = v;
    @(negedge clk);
  endtask

  // {src, mask, cls, exp_irq, exp_fiq}
  localparam logic [121:0] VEC [7] = '{
    {40'h00_00000001, 40'h00_00000001, 40'h00_00000000, 2'b10},
    {40'h00_00000001, 40'h00_00000001, 40'h00_00000001, 2'b01},
    {40'h80_00000000, 40'h80_00000000, 40'h00_00000000, 2'b10},
    {40'h08_00000000, 40'h08_00000000, 40'h08_00000000, 2'b01},
    {40'hFF_FFFFFFFF, 40'h00_00000000, 40'hFF_FFFFFFFF, 2'b00},
    {40'h04_00000008, 40'h04_00000008, 40'h04_00000000, 2'b11},
    {40'h01_0000F000, 40'h01_00003000, 40'h00_00001000, 2'b11}
  };

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; src = '0; halted = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 rdata", rdata, 32'h0);
    chk("R11 irq/fiq/wake", {29'h0, irq, fiq, wake}, 32'h0);
    rd(8'h04, r); chk("R11 mask", r, 32'h0);
    rd(8'hA4, r); chk("R11 cls hi", r, 32'h0);
    rd(8'h1C, r); chk("R11 prio0", r, 32'h0);
    rd(8'h14, r); chk("R5 ctl reset", r, 32'h1);

    // table walk: R2 R3 R4 R1
    foreach (VEC[i]) begin
      logic [39:0] s, m, c;
      logic [39:0] ip, fp;
      s = VEC[i][121:82]; m = VEC[i][81:42]; c = VEC[i][41:2];
      wr(8'h04, m[31:0]); wr(8'hA0, {24'h0, m[39:32]});
      wr(8'h08, c[31:0]); wr(8'hA4, {24'h0, c[39:32]});
      set_src(s);
      chk($sformatf("R3 vec%0d irq", i), {31'h0, irq}, {31'h0, VEC[i][1]});
      chk($sformatf("R3 vec%0d fiq", i), {31'h0, fiq}, {31'h0, VEC[i][0]});
      ip = s & m & ~c; fp = s & m & c;
      rd(8'h00, r); chk($sformatf("R2 vec%0d ipend lo", i), r, ip[31:0]);
      rd(8'h0C, r); chk($sformatf("R2 vec%0d fpend lo", i), r, fp[31:0]);
      rd(8'h9C, r); chk($sformatf("R2 vec%0d ipend hi", i), r, {24'h0, ip[39:32]});
      rd(8'hA8, r); chk($sformatf("R2 vec%0d fpend hi", i), r, {24'h0, fp[39:32]});
      rd(8'h10, r); chk($sformatf("R1 vec%0d raw lo", i), r, s[31:0]);
      rd(8'hAC, r); chk($sformatf("R1 vec%0d raw hi", i), r, {24'h0, s[39:32]});
      rd(8'h08, r); chk($sformatf("R4 vec%0d cls lo", i), r, c[31:0]);
    end

    // R1 level follow, one edge
    wr(8'h04, 32'h0000_0020); wr(8'h08, 32'h0); wr(8'hA0, 32'h0); wr(8'hA4, 32'h0);
    set_src(40'h20);
    chk("R1 rise irq", {31'h0, irq}, 32'h1);
    set_src(40'h0);
    chk("R1 fall irq", {31'h0, irq}, 32'h0);
    rd(8'h10, r); chk("R1 raw after fall", r, 32'h0);

    // R4 R9
    wr(8'h04, 32'hA5A5_A5A5); rd(8'h04, r); chk("R4 mask lo", r, 32'hA5A5_A5A5);
    wr(8'hA0, 32'hFFFF_FFFF); rd(8'hA0, r); chk("R9 mask hi width", r, 32'h0000_00FF);

    // R5 R6
    wr(8'h04, 32'h0); wr(8'hA0, 32'h0);
    halted = 1'b1;
    set_src(40'h20);
    chk("R6 no wake masked", {31'h0, wake}, 32'h0);
    wr(8'h14, 32'h0); rd(8'h14, r); chk("R5 ctl idle set", r, 32'h0);
    chk("R6 wake by idle", {31'h0, wake}, 32'h1);
    chk("R6 idle irq stays 0", {31'h0, irq}, 32'h0);
    wr(8'h14, 32'h1); rd(8'h14, r); chk("R5 ctl idle clr", r, 32'h1);
    chk("R6 wake gone", {31'h0, wake}, 32'h0);
    wr(8'h04, 32'h20);
    chk("R6 wake enabled", {31'h0, wake}, 32'h1);
    halted = 1'b0; @(negedge clk);
    chk("R6 wake not halted", {31'h0, wake}, 32'h0);

    // R7
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, r); chk("R7 prio0 trim", r, 32'h8000_003F);
    wr(8'hCC, 32'h1234_5678); rd(8'hCC, r); chk("R7 prio39 trim", r, 32'h0000_0038);

    // R8
    wr(8'h04, 32'h0010_0400); wr(8'h08, 32'h0);
    set_src(40'h0010_0400);
    wr(8'h1C, 32'h8000_0014); wr(8'h20, 32'h8000_000A);
    rd(8'h18, r); chk("R8 hp irq order", r, 32'h8014_003F);
    wr(8'h08, 32'h0000_0400);
    rd(8'h18, r); chk("R8 hp both", r, 32'h8014_800A);
    wr(8'h1C, 32'h8000_002D); wr(8'h20, 32'h0000_000A);
    rd(8'h18, r); chk("R8 hp none", r, 32'h003F_003F);

    // R10
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); chk("R10 raw write ignored", r, 32'h0010_0400);
    wr(8'h00, 32'h0);  chk("R10 ipend write irq", {31'h0, irq}, 32'h1);
    rd(8'hD0, r); chk("R10 unmapped read", r, 32'h0);
    wr(8'hD0, 32'hFFFF_FFFF); wr(8'h05, 32'h0);
    rd(8'h04, r); chk("R10 unmapped write", r, 32'h0010_0400);

    // R12 hold
    rd(8'h04, r); addr = 8'h08; @(negedge clk);
    chk("R12 rdata hold", rdata, 32'h0010_0400);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule